// File: doc/BRIEF.md
# Frame CRC Generator and Checker

This block computes a 32-bit cyclic redundancy code over the payload words of a frame, one 32-bit word per clock, for a serial storage link controller. It sits on the unscrambled side of the datapath: on the way out it runs before the scrambler, and on the way in it runs after the descrambler. Both directions use a combinational next-state function that takes a full word per cycle. Frames are always whole words, so the block has no byte enables.

The transmit path passes each input word straight through in the same cycle. After the frame's last data word it appends the finished CRC word. The source must leave that following cycle idle. The receive path treats the word flagged as end-of-frame as the received CRC. It compares that word with the CRC of the data words before it, and one cycle later it reports completion with a pulse and, on a mismatch, an error pulse. On both paths, words flagged as primitives pass through or are ignored, and they never enter the calculation. A cycle with valid low freezes the state.

Top module: `crc_frame_unit`

## Requirements
- R1: The CRC uses generator polynomial 0x04C11DB7. Bits are processed most significant first, with bit 31 of each word entering first. There is no reflection and no final inversion, and a full 32-bit word is absorbed in each cycle.
- R2: Every word flagged start-of-frame reloads the register with 0x52325032 before that word is absorbed, so no frame depends on the frame before it.
- R3: A word with the primitive flag high never changes the CRC state, and its start-of-frame and end-of-frame flags are ignored. On transmit it passes through unchanged. On receive it triggers no completion.
- R4: On transmit, every input word appears on the output in the same cycle with the same data, with `tx_valid_o` equal to `tx_valid_i` and `tx_crc_o` low.
- R5: In the cycle after a transmit data word flagged end-of-frame, `tx_valid_o` and `tx_crc_o` are both 1 and `tx_data_o` holds the CRC of every data word of the frame. The source keeps `tx_valid_i` low in that cycle.
- R6: A cycle with valid low leaves the CRC state unchanged on either path, so a frame that pauses produces the same CRC as the same frame sent without pauses.
- R7: On receive, the non-primitive word flagged end-of-frame is the received CRC. In the next cycle `rx_done_o` is 1 for exactly one cycle. In that same cycle `rx_err_o` is 1 only if the received word differs from the CRC of the frame's preceding data words.
- R8: A receive word flagged both start-of-frame and end-of-frame is checked against the seed 0x52325032. This is a frame with no payload.
- R9: While reset is asserted and right after it, `tx_crc_o`, `rx_done_o` and `rx_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Transmit word present |
| tx_sof_i | input | 1 | Transmit word is the first data word of a frame |
| tx_eof_i | input | 1 | Transmit word is the last data word of a frame |
| tx_prim_i | input | 1 | Transmit word is a primitive, excluded from the CRC |
| tx_data_i | input | 32 | Transmit word |
| tx_valid_o | output | 1 | Output word present |
| tx_data_o | output | 32 | Passed-through word, or the appended CRC |
| tx_crc_o | output | 1 | Output word is the appended CRC |
| rx_valid_i | input | 1 | Receive word present |
| rx_sof_i | input | 1 | Receive word is the first word of a frame |
| rx_eof_i | input | 1 | Receive word is the received CRC, ending the frame |
| rx_prim_i | input | 1 | Receive word is a primitive, excluded from the CRC |
| rx_data_i | input | 32 | Receive word |
| rx_done_o | output | 1 | One-cycle pulse after the CRC word is checked |
| rx_err_o | output | 1 | One-cycle pulse when the received CRC mismatches |

## Verification
The assertions rely on two properties of the input streams. The transmit source leaves the cycle after an end-of-frame data word empty, and every frame starts with a data word flagged start-of-frame. The stimulus keeps to both rules. Random frames always begin with a start-of-frame data word, insert pauses and primitives only before data words, and follow each transmit end-of-frame with an idle cycle. Primitives carry random start and end flags, which the block must ignore.

// File: rtl/crc_frame_pkg.sv
package crc_frame_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [WORD_W-1:0] CRC_SEED = 32'h52325032;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/crc_word_step.sv
module crc_word_step #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] stage [W+1];

  assign stage[0] = crc_i;

  // one serial LFSR step per data bit, msb first
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][W-1] ^ data_i[W-1-i];
    assign stage[i+1] = {stage[i][W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  end

  assign crc_o = stage[W];
endmodule

// File: rtl/crc_tx_path.sv
module crc_tx_path #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sof_i,
  input  logic         eof_i,
  input  logic         prim_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         last_o
);
  logic [W-1:0] crc_q, crc_base, crc_nxt;
  logic         take, pend_q;

  assign take     = valid_i & ~prim_i;
  assign crc_base = sof_i ? SEED : crc_q;

  crc_word_step #(.W(W), .POLY(POLY)) u_step (
    .crc_i (crc_base),
    .data_i(data_i),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= SEED;
      pend_q <= 1'b0;
    end else begin
      if (take) crc_q <= crc_nxt;
      pend_q <= take & eof_i;
    end
  end

  assign valid_o = valid_i | pend_q;
  assign data_o  = pend_q ? crc_q : data_i;
  assign last_o  = pend_q;

  assert_slot_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> !valid_i);
  assert_crc_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);
  assert_pause_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(crc_q));
  assert_prim_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prim_i) |=> ($stable(crc_q) && !last_o));
endmodule

// File: rtl/crc_rx_path.sv
module crc_rx_path #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sof_i,
  input  logic         eof_i,
  input  logic         prim_i,
  input  logic [W-1:0] data_i,
  output logic         done_o,
  output logic         err_o
);
  logic [W-1:0] crc_q, crc_base, crc_nxt;
  logic         take, chk, done_q, err_q;

  assign take     = valid_i & ~prim_i;
  assign chk      = take & eof_i;
  assign crc_base = sof_i ? SEED : crc_q;

  crc_word_step #(.W(W), .POLY(POLY)) u_step (
    .crc_i (crc_base),
    .data_i(data_i),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= SEED;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (take && !eof_i) crc_q <= crc_nxt;
      done_q <= chk;
      err_q  <= chk & (data_i != crc_base);
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  assert_err_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_done_after_eof_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && eof_i && !prim_i) |=> !done_o);
  assert_pause_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(crc_q));
  assert_prim_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prim_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc_frame_unit.sv
module crc_frame_unit
  import crc_frame_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter logic [W-1:0] POLY = CRC_POLY,
  parameter logic [W-1:0] SEED = CRC_SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_valid_i,
  input  logic         tx_sof_i,
  input  logic         tx_eof_i,
  input  logic         tx_prim_i,
  input  logic [W-1:0] tx_data_i,
  output logic         tx_valid_o,
  output logic [W-1:0] tx_data_o,
  output logic         tx_crc_o,
  input  logic         rx_valid_i,
  input  logic         rx_sof_i,
  input  logic         rx_eof_i,
  input  logic         rx_prim_i,
  input  logic [W-1:0] rx_data_i,
  output logic         rx_done_o,
  output logic         rx_err_o
);
  crc_tx_path #(.W(W), .POLY(POLY), .SEED(SEED)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(tx_valid_i),
    .sof_i  (tx_sof_i),
    .eof_i  (tx_eof_i),
    .prim_i (tx_prim_i),
    .data_i (tx_data_i),
    .valid_o(tx_valid_o),
    .data_o (tx_data_o),
    .last_o (tx_crc_o)
  );

  crc_rx_path #(.W(W), .POLY(POLY), .SEED(SEED)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rx_valid_i),
    .sof_i  (rx_sof_i),
    .eof_i  (rx_eof_i),
    .prim_i (rx_prim_i),
    .data_i (rx_data_i),
    .done_o (rx_done_o),
    .err_o  (rx_err_o)
  );

  assert_tx_crc_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_crc_o |-> tx_valid_o);
endmodule

// File: tb/sim_crc_frame_unit.sv
module sim_crc_frame_unit;
  localparam logic [31:0] POLY = 32'h04C11DB7;
  localparam logic [31:0] SEED = 32'h52325032;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 0, tx_sof = 0, tx_eof = 0, tx_prim = 0;
  logic [31:0] tx_data = '0;
  logic        tx_valid_o, tx_crc_o;
  logic [31:0] tx_data_o;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_prim = 0;
  logic [31:0] rx_data = '0;
  logic        rx_done_o, rx_err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  crc_frame_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_valid), .tx_sof_i(tx_sof), .tx_eof_i(tx_eof),
    .tx_prim_i(tx_prim), .tx_data_i(tx_data),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_crc_o(tx_crc_o),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .rx_prim_i(rx_prim), .rx_data_i(rx_data),
    .rx_done_o(rx_done_o), .rx_err_o(rx_err_o)
  );

  // reference: xor whole word into the register, then shift 32 times
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c ^ d;
    for (int k = 0; k < 32; k++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tx_put(input bit v, input bit s, input bit e, input bit p,
                        input logic [31:0] d);
    @(negedge clk);
    tx_valid = v; tx_sof = s; tx_eof = e; tx_prim = p; tx_data = d;
    #1;
    chk(tx_valid_o == v, "R4 valid pass", 32'(tx_valid_o), 32'(v));
    chk(tx_crc_o == 1'b0, "R4 no crc flag", 32'(tx_crc_o), 0);
    if (v) chk(tx_data_o == d, p ? "R3 prim pass" : "R4 data pass", tx_data_o, d);
  endtask

  task automatic tx_frame(input int n, input bit pauses, input bit prims);
    logic [31:0] exp = SEED;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      if (pauses && $urandom_range(0, 2) == 0) tx_put(0, 0, 0, 0, $urandom); // R6
      if (prims && $urandom_range(0, 2) == 0)
        tx_put(1, $urandom_range(0, 1), $urandom_range(0, 1), 1, $urandom); // R3
      d = $urandom;
      exp = ref_crc(exp, d);
      tx_put(1, i == 0, i == n - 1, 0, d);
    end
    @(negedge clk);
    tx_valid = 0; tx_sof = 0; tx_eof = 0; tx_prim = 0;
    #1;
    chk(tx_crc_o == 1'b1, "R5 crc flag", 32'(tx_crc_o), 1);
    chk(tx_valid_o == 1'b1, "R5 crc valid", 32'(tx_valid_o), 1);
    chk(tx_data_o == exp, "R5 R1 R2 crc value", tx_data_o, exp);
    @(negedge clk);
    #1;
    chk(tx_crc_o == 1'b0, "R5 single crc word", 32'(tx_crc_o), 0);
  endtask

  task automatic rx_put(input bit v, input bit s, input bit e, input bit p,
                        input logic [31:0] d);
    @(negedge clk);
    rx_valid = v; rx_sof = s; rx_eof = e; rx_prim = p; rx_data = d;
    #1;
    chk(rx_done_o == 1'b0, "R7 R3 no early done", 32'(rx_done_o), 0);
  endtask

  task automatic rx_frame(input int n, input bit bad, input bit pauses, input bit prims);
    logic [31:0] exp = SEED;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      if (pauses && $urandom_range(0, 2) == 0) rx_put(0, 0, 0, 0, $urandom); // R6
      if (prims && $urandom_range(0, 2) == 0)
        rx_put(1, $urandom_range(0, 1), 1, 1, $urandom); // R3 eof on primitive
      d = $urandom;
      exp = ref_crc(exp, d);
      rx_put(1, i == 0, 0, 0, d);
    end
    if (bad) exp = exp ^ (32'h1 << $urandom_range(0, 31));
    rx_put(1, n == 0, 1, 0, exp);
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_prim = 0;
    #1;
    chk(rx_done_o == 1'b1, n == 0 ? "R8 done" : "R7 done", 32'(rx_done_o), 1);
    chk(rx_err_o == bad, n == 0 ? "R8 err" : "R7 err", 32'(rx_err_o), 32'(bad));
    @(negedge clk);
    #1;
    chk(rx_done_o == 1'b0, "R7 done one cycle", 32'(rx_done_o), 0);
  endtask

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    chk(tx_crc_o == 1'b0, "R9 tx crc reset", 32'(tx_crc_o), 0);
    chk(rx_done_o == 1'b0, "R9 done reset", 32'(rx_done_o), 0);
    chk(rx_err_o == 1'b0, "R9 err reset", 32'(rx_err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(tx_crc_o == 1'b0 && rx_done_o == 1'b0 && rx_err_o == 1'b0, "R9 after reset",
        {29'd0, tx_crc_o, rx_done_o, rx_err_o}, 0);

    tx_frame(1, 0, 0);
    tx_frame(5, 0, 0);
    tx_frame(8, 1, 1);
    rx_frame(0, 0, 0, 0);
    rx_frame(0, 1, 0, 0);
    rx_frame(4, 0, 0, 0);
    rx_frame(4, 1, 1, 1);
    for (int j = 0; j < 40; j++) begin
      tx_frame($urandom_range(1, 12), $urandom_range(0, 1), $urandom_range(0, 1));
      rx_frame($urandom_range(0, 12), $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 1));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule